// File: doc/BRIEF.md
# Program Inhibit Guard

This block sits on the device side of a parallel non-volatile memory and decides whether a write strobe may launch an internal program cycle. It watches a logic-level supply-good flag, the three active-low control strobes (chip enable, write enable, output enable) and a free-running system clock. When a write strobe qualifies, it emits a single-cycle program-start pulse. When a strobe is refused, it records why.

Four conditions must all be clear before a program cycle is allowed. The supply must be good. A power-up lockout timer must have run out. Output enable must be high. The strobe window must be long enough. The strobe window is the span during which chip enable and write enable are both low. The lockout restarts every time the supply flag drops. The window is measured in clock samples, so glitches shorter than the programmed minimum are rejected.

Top module: `prog_guard`

## Requirements
- R1: After reset, `start_pulse` is 0 and `reason` is 0 (no rejection recorded).
- R2: A strobe window is accepted if it meets all of the following: it lasts at least `MIN_PULSE` clock samples, and on every sample of the window the supply is good, the lockout is over and `oe_n` is high. An accepted window drives `start_pulse` to 1 for exactly one cycle. That cycle is the one after the first clock sample that sees `ce_n` or `we_n` high.
- R3: The lockout is over only for a sample preceded by at least `LOCK_CYCLES` consecutive samples with `supply_ok` high. A window with any earlier sample is rejected with reason code 2. A drop of `supply_ok` restarts the count.
- R4: A window with any sample where `supply_ok` is low is rejected with reason code 1.
- R5: A window with any sample where `oe_n` is low is rejected with reason code 3.
- R6: A window shorter than `MIN_PULSE` samples is rejected with reason code 4. A window of exactly `MIN_PULSE` samples is accepted.
- R7: When several inhibits apply to one window, the code reported follows the priority 1 (supply), then 2 (lockout), then 3 (output enable), then 4 (short).
- R8: `reason` changes only in the cycle after the trailing edge of a rejected window. An accepted window leaves it unchanged.
- R9: Toggling `we_n` while `ce_n` stays high opens no window. It produces no pulse and does not change `reason`.
- R10: Only the overlap of both enables counts as the window. If `we_n` is held low while `ce_n` dips low briefly, the window is the length of the `ce_n` dip, and its trailing edge is the rise of `ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above threshold, already converted to logic |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| start_pulse | output | 1 | One-cycle program-start pulse |
| reason | output | 3 | Inhibit code of the latest rejected window (0 none, 1 supply, 2 lockout, 3 output enable, 4 short) |

## Verification
The assertions assume that all inputs are already synchronous to `clk` and change only away from its rising edge. The stimulus honours this by driving every input on the falling edge. The assertions also treat a strobe as meaningful only through its sampled values, so sub-cycle glitches are outside their view. Each stimulus window is held for a whole number of clock periods. Supply drops are placed either inside a window or well clear of it, so that the lockout count at every window sample is known to the scoreboard.

// File: rtl/guard_pkg.sv
package guard_pkg;

   typedef enum logic [2:0] {
      RSN_NONE    = 3'd0,
      RSN_SUPPLY  = 3'd1,
      RSN_LOCKOUT = 3'd2,
      RSN_OE      = 3'd3,
      RSN_SHORT   = 3'd4
   } reason_e;

   typedef struct packed {
      logic supply;
      logic lockout;
      logic oe;
   } inhibit_t;

   // Priority: supply, lockout, output enable, short window (R7)
   function automatic reason_e pick_reason(inhibit_t f, logic too_short);
      if (f.supply)       return RSN_SUPPLY;
      else if (f.lockout) return RSN_LOCKOUT;
      else if (f.oe)      return RSN_OE;
      else if (too_short) return RSN_SHORT;
      else                return RSN_NONE;
   endfunction

endpackage

// File: rtl/lockout_timer.sv
module lockout_timer #(
   parameter int LOCK_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   output logic lock_ok
);
   localparam int LW = $clog2(LOCK_CYCLES + 1);
   localparam logic [LW-1:0] LIMIT = LW'(LOCK_CYCLES);

   logic [LW-1:0] cnt;

   // Restarts on every supply drop (R3)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!supply_ok)     cnt <= '0;
      else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
   end

   assign lock_ok = (cnt == LIMIT);
endmodule

// File: rtl/strobe_window.sv
module strobe_window #(
   parameter int MIN_PULSE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   output logic active,
   output logic in_win,
   output logic trail,
   output logic long_enough
);
   assign active = !ce_n && !we_n;   // overlap only (R10)

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_win <= 1'b0;
      else        in_win <= active;
   end

   assign trail = in_win && !active;

   generate
      if (MIN_PULSE == 1) begin : g_nofilt
         assign long_enough = 1'b1;
      end else begin : g_filt
         localparam int PW = $clog2(MIN_PULSE + 1);
         localparam logic [PW-1:0] PMAX = PW'(MIN_PULSE);
         logic [PW-1:0] wcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               wcnt <= '0;
            else if (active) begin
               if (!in_win)           wcnt <= PW'(1);
               else if (wcnt != PMAX) wcnt <= wcnt + 1'b1;
            end
         end
         assign long_enough = (wcnt == PMAX);
      end
   endgenerate
endmodule

// File: rtl/inhibit_accum.sv
module inhibit_accum
   import guard_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     active,
   input  logic     in_win,
   input  inhibit_t cur,
   output inhibit_t acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc <= '0;
      else if (active) acc <= (in_win ? acc : inhibit_t'('0)) | cur;
   end
endmodule

// File: rtl/prog_guard.sv
module prog_guard
   import guard_pkg::*;
#(
   parameter int LOCK_CYCLES = 1000,
   parameter int MIN_PULSE   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  logic       ce_n,
   input  logic       we_n,
   input  logic       oe_n,
   output logic       start_pulse,
   output logic [2:0] reason
);
   generate
      if (LOCK_CYCLES < 1) begin : g_bad_lock
         $error("LOCK_CYCLES must be at least 1");
      end
      if (MIN_PULSE < 1) begin : g_bad_pulse
         $error("MIN_PULSE must be at least 1");
      end
   endgenerate

   logic     lock_ok;
   logic     active, in_win, trail, long_enough;
   inhibit_t cur, acc;
   reason_e  rsn_q;

   lockout_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .lock_ok(lock_ok)
   );

   strobe_window #(.MIN_PULSE(MIN_PULSE)) u_win (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
      .active(active), .in_win(in_win), .trail(trail),
      .long_enough(long_enough)
   );

   always_comb begin
      cur.supply  = !supply_ok;
      cur.lockout = !lock_ok;
      cur.oe      = !oe_n;
   end

   inhibit_accum u_acc (
      .clk(clk), .rst_n(rst_n), .active(active), .in_win(in_win),
      .cur(cur), .acc(acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pulse <= 1'b0;
         rsn_q       <= RSN_NONE;
      end else begin
         start_pulse <= 1'b0;
         if (trail) begin
            if (acc == '0 && long_enough) start_pulse <= 1'b1;
            else                          rsn_q <= pick_reason(acc, !long_enough);
         end
      end
   end

   assign reason = rsn_q;
endmodule

// File: rtl/prog_guard_chk.sv
module prog_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       supply_ok,
   input logic       ce_n,
   input logic       we_n,
   input logic       oe_n,
   input logic       lock_ok,
   input logic       start_pulse,
   input logic [2:0] reason
);
   a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

   a_r2_after_trailing_edge: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> ($past(ce_n || we_n) && $past(!ce_n && !we_n, 2)));

   a_r3_drop_restarts_lockout: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !lock_ok);

   a_r3_armed_before_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(lock_ok, 2));

   a_r4_supply_good: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(supply_ok, 2));

   a_r5_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(oe_n, 2));

   a_r8_reason_only_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reason) |-> !start_pulse);

   a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      reason <= 3'd4);
endmodule

bind prog_guard prog_guard_chk u_chk (
   .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n),
   .we_n(we_n), .oe_n(oe_n), .lock_ok(lock_ok),
   .start_pulse(start_pulse), .reason(reason)
);

// File: tb/sim_prog_guard.sv
module sim_prog_guard;
   localparam int CLK_PERIOD = 10;
   localparam int LOCK = 40;
   localparam int MINP = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic supply_ok = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic start_pulse;
   logic [2:0] reason;

   int checks = 0, errors = 0, cyc = 0;
   bit running = 1'b0;

   typedef struct {
      int         due;
      bit         st;
      logic [2:0] rsn;
      string      tag;
   } exp_t;
   exp_t q[$];

   prog_guard #(.LOCK_CYCLES(LOCK), .MIN_PULSE(MINP)) u0 (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n),
      .we_n(we_n), .oe_n(oe_n), .start_pulse(start_pulse), .reason(reason)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Monitor: pops expected results in their due cycle
   always @(negedge clk) begin
      if (running) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(start_pulse == e.st, {e.tag, " start"}, int'(start_pulse), int'(e.st));
            chk(reason == e.rsn, {e.tag, " reason"}, int'(reason), int'(e.rsn));
         end else if (start_pulse) begin
            chk(1'b0, "R2 unexpected pulse", 1, 0);
         end
      end
   end

   task automatic push(bit st, logic [2:0] rsn, string tag);
      exp_t e;
      e.due = cyc + 1; e.st = st; e.rsn = rsn; e.tag = tag;
      q.push_back(e);
   endtask

   // Driver: one strobe window of k samples
   task automatic attempt(int k, bit oe_low, bit sup_low, bit st,
                          logic [2:0] rsn, string tag);
      oe_n = !oe_low;
      if (sup_low) supply_ok = 1'b0;
      ce_n = 1'b0; we_n = 1'b0;
      repeat (k) @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; supply_ok = 1'b1;
      push(st, rsn, tag);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(start_pulse == 1'b0, "R1 start after reset", int'(start_pulse), 0);
      chk(reason == 3'd0, "R1 reason after reset", int'(reason), 0);
      running = 1'b1;

      // R3: window right after supply rises
      supply_ok = 1'b1;
      attempt(4, 0, 0, 0, 3'd2, "R3 lockout");
      repeat (LOCK + 5) @(negedge clk);
      attempt(4, 0, 0, 1, 3'd2, "R2 accept keeps reason R8");

      // R6 boundary
      attempt(MINP - 1, 0, 0, 0, 3'd4, "R6 short");
      attempt(MINP, 0, 0, 1, 3'd4, "R6 exact min accepted R8");

      // R5 and R7 (oe over short)
      attempt(5, 1, 0, 0, 3'd3, "R5 oe low");
      attempt(1, 0, 0, 0, 3'd4, "R6 single sample");
      attempt(1, 1, 0, 0, 3'd3, "R7 oe beats short");

      // R4, supply drop inside window (lockout also set; supply wins, R7)
      attempt(4, 0, 1, 0, 3'd1, "R4 supply low");
      attempt(4, 0, 0, 0, 3'd2, "R3 restart after drop");
      repeat (LOCK + 5) @(negedge clk);
      attempt(4, 0, 0, 1, 3'd2, "R3 rearmed");

      // R7: lockout over oe
      supply_ok = 1'b0;
      repeat (2) @(negedge clk);
      supply_ok = 1'b1;
      attempt(4, 1, 0, 0, 3'd2, "R7 lockout beats oe");
      repeat (LOCK + 5) @(negedge clk);

      // R9: we_n toggles with ce_n high
      repeat (6) begin
         we_n = 1'b0; @(negedge clk);
         we_n = 1'b1; @(negedge clk);
      end
      repeat (3) @(negedge clk);
      chk(reason == 3'd2, "R9 reason untouched", int'(reason), 2);
      chk(start_pulse == 1'b0, "R9 no pulse", int'(start_pulse), 0);

      // R10: overlap defines the window
      we_n = 1'b0;
      repeat (3) @(negedge clk);
      ce_n = 1'b0;
      repeat (2) @(negedge clk);
      ce_n = 1'b1;
      push(0, 3'd4, "R10 short overlap");
      repeat (3) @(negedge clk);
      ce_n = 1'b0;
      repeat (4) @(negedge clk);
      ce_n = 1'b1;
      push(1, 3'd4, "R10 long overlap");
      repeat (3) @(negedge clk);
      we_n = 1'b1;

      repeat (5) @(negedge clk);
      chk(q.size() == 0, "R2 all results seen", q.size(), 0);
      finish_run();
   end
endmodule